// File: doc/BRIEF.md
# Synchronizer Mode Control FSM

This block decides the operating state of a two-reference digital PLL. It holds the PLL in a reset state for a few milliseconds after reset is released. It then follows the mode-select input. In freerun it runs from the local oscillator alone. In normal-select operation it moves automatically between holdover, a phase-offset capture step and locked normal operation. The moves depend on whether the selected reference is disrupted and on whether the reference-select input changes.

Alongside the state, the block drives four things. The first is a one-cycle strobe that tells the phase-offset store to capture the current offset. The second is a flag saying whether a captured offset is in force. The third is an enable for the clock and frame outputs. The fourth is the lock indicator. Lock qualifies over a programmable number of millisecond ticks inside the phase window. It survives a short holdover for a grace period and drops at once in freerun. All timing is counted in ticks of the `tick_ms` input.

Top module: `sync_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, and after its release until `RST_HOLD_MS` ticks have been counted, `state_o` is 0 (reset), `out_en` is 0 and `lock` is 0.
- R2: On the last reset-hold tick the state becomes 2 (holdover) when `mode_free` is 0, or 1 (freerun) when it is 1.
- R3: In state 4 (normal) or 3 (capture), either a high `ref_dis` or a change of `ref_sel` since the previous cycle moves the state to 2 at the next edge.
- R4: In state 2 with `ref_dis` low, the state moves to 3 for exactly one cycle and then to 4.
- R5: `tie_cap` is high for exactly the one cycle in which the state is 3, provided `tie_clr_n` is high; entering state 3 with `tie_clr_n` high sets `tie_keep` to 1.
- R6: In state 4, `lock` rises after `phase_in_win` has stayed high for `LOCK_QUAL_MS` consecutive ticks; a low `phase_in_win` clears `lock` and restarts the count.
- R7: On entry to state 2, `lock` keeps its value; after `HOLD_GRACE_MS` ticks in state 2 it goes low, and a return to normal before then keeps it unchanged.
- R8: Outside reset, `mode_free` high moves the state to 1 at the next edge with `lock` low in that same cycle; `mode_free` low in state 1 moves the state to 2.
- R9: While `tie_clr_n` is low, `tie_keep` is 0 and `tie_cap` does not fire; once `tie_clr_n` returns high, `tie_keep` stays 0 until the next entry into state 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| mode_free | input | 1 | 1 selects freerun, 0 normal operation |
| ref_sel | input | 1 | Selected reference index |
| ref_dis | input | 1 | Selected reference disrupted |
| phase_in_win | input | 1 | Phase error inside the lock window |
| tie_clr_n | input | 1 | Active-low clear of the stored phase offset |
| state_o | output | 3 | 0 reset, 1 freerun, 2 holdover, 3 capture, 4 normal |
| tie_cap | output | 1 | One-cycle offset capture strobe |
| tie_keep | output | 1 | 1 when a captured phase offset is in force |
| out_en | output | 1 | Clock and frame output enable (0 means high impedance) |
| lock | output | 1 | Lock indicator |

## Verification
The bench sweeps the tick count one short of each limit (reset hold, lock qualify, holdover grace) and then exactly at the limit. A counter off by one therefore shows up as a state or lock value one tick early or late. It raises reference changes and disruptions in both normal and capture states. A design that ignored the select edge would stay in normal and skip the offset recapture. It also checks that a quick return from holdover keeps lock high, that freerun drops lock in the very cycle it is entered, and that a clear input released without a new capture leaves the offset cleared. A design that restored the old offset would raise `tie_keep` too early.

// File: rtl/sync_mode_ctrl.sv
module sync_mode_ctrl #(
  parameter int RST_HOLD_MS   = 3,
  parameter int LOCK_QUAL_MS  = 1000,
  parameter int HOLD_GRACE_MS = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       mode_free,
  input  logic       ref_sel,
  input  logic       ref_dis,
  input  logic       phase_in_win,
  input  logic       tie_clr_n,
  output logic [2:0] state_o,
  output logic       tie_cap,
  output logic       tie_keep,
  output logic       out_en,
  output logic       lock
);
  localparam int CMAX0 = (RST_HOLD_MS > LOCK_QUAL_MS) ? RST_HOLD_MS : LOCK_QUAL_MS;
  localparam int CMAX  = (CMAX0 > HOLD_GRACE_MS) ? CMAX0 : HOLD_GRACE_MS;
  localparam int CW    = $clog2(CMAX + 1);
  localparam logic [2:0] S_RST = 3'd0, S_FREE = 3'd1, S_HOLD = 3'd2,
                         S_TIE = 3'd3, S_NORM = 3'd4;

  logic [2:0]    state, nxt;
  logic [CW-1:0] cnt, cnt_n;
  logic          ref_q, lock_n;

  wire bad      = ref_dis | (ref_sel ^ ref_q);
  wire rst_done = tick_ms && (cnt == CW'(RST_HOLD_MS - 1));
  wire grace_up = tick_ms && (cnt == CW'(HOLD_GRACE_MS - 1));
  wire qual_up  = tick_ms && (cnt == CW'(LOCK_QUAL_MS - 1));
  wire tie_in   = (nxt == S_TIE) && (state != S_TIE);

  always_comb begin
    nxt = state;
    case (state)
      S_RST:  if (rst_done) nxt = mode_free ? S_FREE : S_HOLD;
      S_FREE: if (!mode_free) nxt = S_HOLD;
      S_HOLD: if (!ref_dis) nxt = S_TIE;
      S_TIE:  nxt = bad ? S_HOLD : S_NORM;
      S_NORM: if (bad) nxt = S_HOLD;
      default: nxt = S_RST;
    endcase
    if (state != S_RST && mode_free) nxt = S_FREE;
  end

  always_comb begin
    cnt_n = cnt;
    if (nxt != state) cnt_n = '0;
    else case (state)
      S_RST:  if (tick_ms) cnt_n = cnt + 1'b1;
      S_HOLD: if (tick_ms && cnt < CW'(HOLD_GRACE_MS)) cnt_n = cnt + 1'b1;
      S_NORM: if (!phase_in_win) cnt_n = '0;
              else if (tick_ms && cnt < CW'(LOCK_QUAL_MS)) cnt_n = cnt + 1'b1;
      default: cnt_n = cnt;
    endcase
  end

  always_comb begin
    case (nxt)
      S_HOLD: lock_n = (state == S_HOLD && grace_up) ? 1'b0 : lock;
      S_TIE:  lock_n = lock;
      S_NORM: if (state != S_NORM) lock_n = lock;
              else if (!phase_in_win) lock_n = 1'b0;
              else if (qual_up) lock_n = 1'b1;
              else lock_n = lock;
      default: lock_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_RST;
      cnt      <= '0;
      ref_q    <= 1'b0;
      lock     <= 1'b0;
      tie_cap  <= 1'b0;
      tie_keep <= 1'b0;
    end else begin
      state    <= nxt;
      cnt      <= cnt_n;
      ref_q    <= ref_sel;
      lock     <= lock_n;
      tie_cap  <= tie_in && tie_clr_n;
      tie_keep <= !tie_clr_n ? 1'b0 : (tie_in ? 1'b1 : tie_keep);
    end
  end

  assign state_o = state;
  assign out_en  = (state != S_RST);
endmodule

// File: rtl/sync_mode_ctrl_chk.sv
module sync_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_free,
  input logic       ref_dis,
  input logic       phase_in_win,
  input logic [2:0] state_o,
  input logic       tie_cap,
  input logic       out_en,
  input logic       lock
);
  localparam logic [2:0] S_RST = 3'd0, S_FREE = 3'd1, S_HOLD = 3'd2,
                         S_TIE = 3'd3, S_NORM = 3'd4;

  p_nolock_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !lock);

  p_disrupt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == S_NORM || state_o == S_TIE) && ref_dis && !mode_free) |=> state_o == S_HOLD);

  p_tie_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == S_TIE |=> state_o != S_TIE);

  p_cap_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tie_cap |-> (state_o == S_TIE) && ($past(state_o) != S_TIE));

  p_cap_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tie_cap |=> !tie_cap);

  p_lock_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> (state_o == S_NORM) && $past(phase_in_win));

  p_free_now_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_free && state_o != S_RST) |=> (state_o == S_FREE) && !lock);
endmodule

bind sync_mode_ctrl sync_mode_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .mode_free(mode_free), .ref_dis(ref_dis),
  .phase_in_win(phase_in_win), .state_o(state_o), .tie_cap(tie_cap),
  .out_en(out_en), .lock(lock)
);

// File: tb/test_sync_mode_ctrl.sv
module test_sync_mode_ctrl;
  localparam int RH = 3, LQ = 1000, HG = 100;
  localparam logic [2:0] S_RST = 0, S_FREE = 1, S_HOLD = 2, S_TIE = 3, S_NORM = 4;

  logic clk = 0, rst_n = 0, tick_ms = 0, mode_free = 0, ref_sel = 0;
  logic ref_dis = 1, phase_in_win = 0, tie_clr_n = 1;
  logic [2:0] state_o;
  logic tie_cap, tie_keep, out_en, lock;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  sync_mode_ctrl #(.RST_HOLD_MS(RH), .LOCK_QUAL_MS(LQ), .HOLD_GRACE_MS(HG)) i_sync_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .mode_free(mode_free),
    .ref_sel(ref_sel), .ref_dis(ref_dis), .phase_in_win(phase_in_win),
    .tie_clr_n(tie_clr_n), .state_o(state_o), .tie_cap(tie_cap),
    .tie_keep(tie_keep), .out_en(out_en), .lock(lock));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin tick_ms = 1; step(); end
    tick_ms = 0;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    #5;
    chk("R1 state in reset", state_o, S_RST);
    chk("R1 out_en in reset", out_en, 0);
    chk("R1 lock in reset", lock, 0);
    step(); rst_n = 1;
    for (int i = 0; i < 4; i++) step();
    chk("R1 no ticks keeps reset", state_o, S_RST);
    tk(RH - 1);
    chk("R1 hold one tick short", state_o, S_RST);
    chk("R1 out_en one tick short", out_en, 0);
    tk(1);
    chk("R2 holdover after hold", state_o, S_HOLD);
    chk("R2 out_en after hold", out_en, 1);
    for (int i = 0; i < 3; i++) step();
    chk("R4 disrupted stays holdover", state_o, S_HOLD);
    ref_dis = 0; step();
    chk("R4 enter capture", state_o, S_TIE);
    chk("R5 capture strobe", tie_cap, 1);
    chk("R5 keep set", tie_keep, 1);
    step();
    chk("R4 capture to normal", state_o, S_NORM);
    chk("R5 strobe one cycle", tie_cap, 0);

    phase_in_win = 1;
    tk(LQ - 1); chk("R6 lock one tick short", lock, 0);
    tk(1);      chk("R6 lock at qualify", lock, 1);
    phase_in_win = 0; step(); chk("R6 window exit drops lock", lock, 0);
    phase_in_win = 1;
    tk(LQ - 1); chk("R6 qualify restarted", lock, 0);
    tk(1);      chk("R6 relock", lock, 1);

    ref_dis = 1; step();
    chk("R3 disrupt to holdover", state_o, S_HOLD);
    chk("R7 lock kept on entry", lock, 1);
    tk(HG - 1); chk("R7 lock one tick short of grace", lock, 1);
    tk(1);      chk("R7 lock drops after grace", lock, 0);
    ref_dis = 0; step(); step();
    chk("R4 back to normal", state_o, S_NORM);
    tk(LQ); chk("R6 lock after recovery", lock, 1);

    ref_dis = 1; step(); tk(HG / 2);
    ref_dis = 0; step(); step();
    chk("R7 quick return state", state_o, S_NORM);
    chk("R7 quick return keeps lock", lock, 1);

    for (int i = 0; i < 2; i++) begin
      ref_sel = ~ref_sel; step();
      chk("R3 select change in normal", state_o, S_HOLD);
      step(); chk("R4 recapture after change", state_o, S_TIE);
      chk("R5 strobe after change", tie_cap, 1);
      step(); chk("R4 normal after change", state_o, S_NORM);
    end
    for (int i = 0; i < 2; i++) begin
      ref_dis = 1; step(); ref_dis = 0; step();
      chk("R4 capture reached", state_o, S_TIE);
      if (i == 0) ref_sel = ~ref_sel; else ref_dis = 1;
      step();
      chk("R3 capture aborted", state_o, S_HOLD);
      ref_dis = 0; step(); step();
      chk("R4 normal after abort", state_o, S_NORM);
    end

    chk("R8 precondition lock", lock, 1);
    mode_free = 1; step();
    chk("R8 freerun entered", state_o, S_FREE);
    chk("R8 lock low at once", lock, 0);
    step(); chk("R8 freerun held", state_o, S_FREE);
    mode_free = 0; step();
    chk("R8 freerun exit to holdover", state_o, S_HOLD);
    ref_dis = 1; step();
    mode_free = 1; step(); chk("R8 freerun from holdover", state_o, S_FREE);
    mode_free = 0; step(); chk("R8 exit again", state_o, S_HOLD);

    chk("R9 keep before clear", tie_keep, 1);
    tie_clr_n = 0; step();
    chk("R9 clear drops keep", tie_keep, 0);
    ref_dis = 0; step();
    chk("R9 capture state under clear", state_o, S_TIE);
    chk("R9 no strobe under clear", tie_cap, 0);
    chk("R9 keep stays clear", tie_keep, 0);
    step(); tie_clr_n = 1; step();
    chk("R9 keep stays 0 after release", tie_keep, 0);
    ref_dis = 1; step(); ref_dis = 0; step();
    chk("R9 strobe returns", tie_cap, 1);
    chk("R9 keep after new capture", tie_keep, 1);

    mode_free = 1; rst_n = 0; #1;
    chk("R1 reset mid-run state", state_o, S_RST);
    chk("R1 reset mid-run out_en", out_en, 0);
    chk("R1 reset mid-run lock", lock, 0);
    step(); rst_n = 1;
    tk(RH - 1); chk("R1 second hold", state_o, S_RST);
    tk(1);      chk("R2 freerun after hold", state_o, S_FREE);
    chk("R2 out_en after hold", out_en, 1);
    finish_run();
  end
endmodule